// File: doc/BRIEF.md
# Stochastic Bitstream Encoder

This block converts an unsigned level into a serial stream of bits in which the density of ones tracks the level divided by 2^W (W = 16 by default). A W-bit shift register with linear feedback supplies a pseudo-random word. On each enabled clock edge a comparator weighs that word against the level and produces one stream bit. The shift register then advances by one step.

The shift register restarts from a built-in seed on reset. Software-side logic can also plant a new seed through a write strobe. A zero seed would lock the register at zero, so a write carrying zero is refused and reported on a sticky fault flag. The stream output is registered, so each bit appears one clock after the edge that produced it.

Top module: `stoch_bit_encoder`

## Requirements
- R1: While `rst` is high at a rising edge, the internal word becomes INIT_SEED (default 16'hACE1), `stream_bit` becomes 0 and `seed_fault` becomes 0.
- R2: On a step, the word shifts left by one and the new bit 0 is the XOR of the previous word's bits 15, 13, 12 and 10 (tap mask 16'hB400).
- R3: A step happens on an edge where `rst` is low, `seed_wr` is low and `step_en` is high. After that edge, `stream_bit` is 1 exactly when the word held before the edge is strictly less than `level`, compared unsigned.
- R4: On an edge with `rst`, `seed_wr` and `step_en` all low, the word and `stream_bit` keep their values.
- R5: When `seed_wr` is high and `seed_val` is nonzero, the word takes `seed_val` and `seed_fault` clears. This happens whatever `step_en` is, and `stream_bit` holds.
- R6: When `seed_wr` is high and `seed_val` is zero, the word and `stream_bit` are unchanged even if `step_en` is high. `seed_fault` is then set and stays set until a valid seed write or a reset.
- R7: A reset after a seed write restores INIT_SEED, not the written seed.
- R8: A step with `level` 0 always yields 0. A step with `level` 16'hFFFF yields 1 unless the word is 16'hFFFF, in which case it yields 0.
- R9: The word is never zero after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| step_en | input | 1 | Produce one bit and advance the word |
| level | input | 16 | Unsigned level to encode |
| seed_wr | input | 1 | Seed write strobe |
| seed_val | input | 16 | Seed carried by the write |
| stream_bit | output | 1 | Registered stream bit |
| seed_fault | output | 1 | Sticky flag for a refused zero seed |

## Verification
The assertions expect `rst` to be high at the first rising edge. They also expect every input to be a known 0 or 1 at each edge, because the control decode does not resolve X. The bench holds reset from time zero for two cycles and changes inputs only on falling edges. A reference model in the bench tracks the word and predicts every stream bit. The stimulus covers random levels, levels exactly at and one above the predicted word, seed writes made together with enable, and zero-seed writes.

// File: rtl/sbe_pkg.sv
package sbe_pkg;
  // Per-cycle action chosen by the control decoder.
  typedef enum logic [2:0] {
    ACT_IDLE   = 3'd0,
    ACT_STEP   = 3'd1,
    ACT_LOAD   = 3'd2,
    ACT_REJECT = 3'd3,
    ACT_RESET  = 3'd4
  } sbe_act_e;
endpackage

// File: rtl/sbe_ctrl.sv
module sbe_ctrl
  import sbe_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     step_en,
  input  logic     seed_wr,
  input  logic     seed_zero,
  output sbe_act_e act,
  output logic     fault
);
  // Priority: reset, then seed write, then step.
  always_comb begin
    if (rst)          act = ACT_RESET;
    else if (seed_wr) act = seed_zero ? ACT_REJECT : ACT_LOAD;
    else if (step_en) act = ACT_STEP;
    else              act = ACT_IDLE;
  end

  always_ff @(posedge clk) begin
    case (act)
      ACT_RESET, ACT_LOAD: fault <= 1'b0;
      ACT_REJECT:          fault <= 1'b1;
      default:             fault <= fault;
    endcase
  end

  // R6: a refused zero seed raises the flag
  p_fault_set_r6: assert property (@(posedge clk) disable iff (rst)
    (seed_wr && seed_zero) |=> fault);
  // R5: a valid seed write clears the flag
  p_fault_clear_r5: assert property (@(posedge clk) disable iff (rst)
    (seed_wr && !seed_zero) |=> !fault);
  // R6: flag is sticky while no write occurs
  p_fault_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    (!seed_wr && fault) |=> fault);
endmodule

// File: rtl/sbe_lfsr.sv
module sbe_lfsr
  import sbe_pkg::*;
#(
  parameter int unsigned W         = 16,
  parameter logic [W-1:0] TAPS      = 16'hB400,
  parameter logic [W-1:0] INIT_SEED = 16'hACE1
) (
  input  logic         clk,
  input  logic         rst,
  input  sbe_act_e     act,
  input  logic [W-1:0] seed,
  output logic [W-1:0] word
);
  logic feedback;
  assign feedback = ^(word & TAPS);

  always_ff @(posedge clk) begin
    case (act)
      ACT_RESET: word <= INIT_SEED;
      ACT_LOAD:  word <= seed;
      ACT_STEP:  word <= {word[W-2:0], feedback};
      default:   word <= word;
    endcase
  end

  // R1 / R7: reset restores the built-in seed
  p_reset_seed_r1: assert property (@(posedge clk)
    rst |=> word == INIT_SEED);
  // R2: left shift with tap feedback at bit 0
  p_shift_r2: assert property (@(posedge clk) disable iff (rst)
    act == ACT_STEP |=> word == {$past(word[W-2:0]), ^($past(word) & TAPS)});
  // R5: valid seed write lands in the word
  p_load_r5: assert property (@(posedge clk) disable iff (rst)
    act == ACT_LOAD |=> word == $past(seed));
  // R6: refused seed leaves the word alone
  p_reject_r6: assert property (@(posedge clk) disable iff (rst)
    act == ACT_REJECT |=> $stable(word));
  // R9: word never reaches zero
  p_nonzero_r9: assert property (@(posedge clk) disable iff (rst)
    act != ACT_RESET |=> word != '0);
endmodule

// File: rtl/sbe_cmp.sv
module sbe_cmp #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] word,
  input  logic [W-1:0] level,
  output logic         below
);
  // Unsigned strict compare against the pre-step word.
  assign below = (word < level);
endmodule

// File: rtl/stoch_bit_encoder.sv
module stoch_bit_encoder
  import sbe_pkg::*;
#(
  parameter int unsigned W         = 16,
  parameter logic [W-1:0] TAPS      = 16'hB400,
  parameter logic [W-1:0] INIT_SEED = 16'hACE1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step_en,
  input  logic [W-1:0] level,
  input  logic         seed_wr,
  input  logic [W-1:0] seed_val,
  output logic         stream_bit,
  output logic         seed_fault
);
  localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

  sbe_act_e     act;
  logic [W-1:0] word;
  logic         below;

  sbe_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .step_en  (step_en),
    .seed_wr  (seed_wr),
    .seed_zero(seed_val == '0),
    .act      (act),
    .fault    (seed_fault)
  );

  sbe_lfsr #(.W(W), .TAPS(TAPS), .INIT_SEED(INIT_SEED)) u_lfsr (
    .clk (clk),
    .rst (rst),
    .act (act),
    .seed(seed_val),
    .word(word)
  );

  sbe_cmp #(.W(W)) u_cmp (
    .word (word),
    .level(level),
    .below(below)
  );

  always_ff @(posedge clk) begin
    if (act == ACT_RESET)     stream_bit <= 1'b0;
    else if (act == ACT_STEP) stream_bit <= below;
  end

  // R1: output clears on reset
  p_reset_out_r1: assert property (@(posedge clk) rst |=> !stream_bit && !seed_fault);
  // R4: idle edge holds the output and the word
  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (!seed_wr && !step_en) |=> $stable(stream_bit) && $stable(word));
  // R5 / R6: a seed write never moves the output
  p_wr_hold_r5: assert property (@(posedge clk) disable iff (rst)
    seed_wr |=> $stable(stream_bit));
  // R8: zero level never yields a one
  p_zero_level_r8: assert property (@(posedge clk) disable iff (rst)
    (step_en && !seed_wr && level == '0) |=> !stream_bit);
  // R8: full-scale level yields one unless the word is all ones
  p_full_level_r8: assert property (@(posedge clk) disable iff (rst)
    (step_en && !seed_wr && level == ALL_ONES && word != ALL_ONES) |=> stream_bit);
endmodule

// File: tb/stoch_bit_encoder_tb_top.sv
module stoch_bit_encoder_tb_top;
  localparam logic [15:0] INIT = 16'hACE1;
  localparam logic [15:0] TAPS = 16'hB400;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        step_en = 1'b0;
  logic [15:0] level = '0;
  logic        seed_wr = 1'b0;
  logic [15:0] seed_val = '0;
  logic        stream_bit;
  logic        seed_fault;

  always #10 clk = ~clk;  // 50 MHz

  stoch_bit_encoder dut_i (
    .clk(clk), .rst(rst), .step_en(step_en), .level(level),
    .seed_wr(seed_wr), .seed_val(seed_val),
    .stream_bit(stream_bit), .seed_fault(seed_fault)
  );

  typedef struct {
    logic  b;
    logic  f;
    string tag;
  } exp_t;
  exp_t q[$];

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // Reference model state
  logic [15:0] m_word = INIT;
  logic        m_bit  = 1'b0;
  logic        m_flt  = 1'b0;

  task automatic drive(input logic r, input logic e, input logic [15:0] v,
                       input logic w, input logic [15:0] s, input string tag);
    exp_t x;
    @(negedge clk);
    rst = r; step_en = e; level = v; seed_wr = w; seed_val = s;
    if (r) begin
      m_word = INIT; m_bit = 1'b0; m_flt = 1'b0;
    end else if (w) begin
      if (s != 16'h0) begin m_word = s; m_flt = 1'b0; end
      else m_flt = 1'b1;
    end else if (e) begin
      m_bit  = (m_word < v);
      m_word = {m_word[14:0], ^(m_word & TAPS)};
    end
    x.b = m_bit; x.f = m_flt; x.tag = tag;
    q.push_back(x);
  endtask

  // Monitor: sample 5 ns after each rising edge
  always begin
    exp_t x;
    @(posedge clk);
    #5;
    if (q.size() > 0) begin
      x = q.pop_front();
      checks++;
      if (stream_bit !== x.b || seed_fault !== x.f) begin
        fails++;
        $display("FAIL %s actual bit=%b fault=%b expected bit=%b fault=%b",
                 x.tag, stream_bit, seed_fault, x.b, x.f);
      end
    end
  end

  initial begin
    // R1: reset state
    drive(1, 0, 16'h0, 0, 16'h0, "R1 reset");
    drive(1, 1, 16'hFFFF, 0, 16'h0, "R1 reset");
    // R3: compare boundaries against the predicted word
    drive(0, 1, m_word + 16'd1, 0, 16'h0, "R3 level=word+1");
    drive(0, 1, m_word, 0, 16'h0, "R3 level=word");
    drive(0, 1, m_word + 16'd1, 0, 16'h0, "R3 level=word+1");
    // R2/R3: random levels over a long stream
    for (int i = 0; i < 300; i++)
      drive(0, 1, 16'($urandom()), 0, 16'h0, "R2 R3 random stream");
    // R4: enable low holds, levels that would flip the bit
    drive(0, 1, m_word + 16'd1, 0, 16'h0, "R3 set one");
    for (int i = 0; i < 4; i++)
      drive(0, 0, 16'h0, 0, 16'h0, "R4 hold");
    drive(0, 1, m_word, 0, 16'h0, "R4 word held then R3");
    // R5: seed write with step enable, output holds
    drive(0, 1, 16'h0, 0, 16'h0, "R3 clear bit");
    drive(0, 1, 16'hFFFF, 1, 16'h0001, "R5 load with enable");
    drive(0, 1, 16'h0002, 0, 16'h0, "R5 word=1 probe");
    drive(0, 1, 16'h0002, 0, 16'h0, "R5 R2 word=2 probe");
    // R6: zero seed refused, sticky flag, word untouched
    drive(0, 1, 16'hFFFF, 1, 16'h0000, "R6 zero seed");
    drive(0, 0, 16'h0, 0, 16'h0, "R6 sticky");
    drive(0, 1, m_word + 16'd1, 0, 16'h0, "R6 word unchanged");
    drive(0, 1, m_word, 0, 16'h0, "R6 word unchanged");
    drive(0, 1, 16'($urandom()), 0, 16'h0, "R6 sticky while stepping");
    drive(0, 0, 16'h0, 1, 16'h1234, "R5 valid write clears fault");
    drive(0, 1, 16'h1235, 0, 16'h0, "R5 word=1234 probe");
    // R8: zero level stream
    for (int i = 0; i < 20; i++)
      drive(0, 1, 16'h0000, 0, 16'h0, "R8 level zero");
    // R8: full scale, including the all-ones word
    drive(0, 0, 16'h0, 1, 16'hFFFF, "R5 load all ones");
    drive(0, 1, 16'hFFFF, 0, 16'h0, "R8 full level word=FFFF");
    for (int i = 0; i < 20; i++)
      drive(0, 1, 16'hFFFF, 0, 16'h0, "R8 full level");
    // R7: reset after a write restores the built-in seed
    drive(0, 0, 16'h0, 1, 16'h0000, "R6 fault before reset");
    drive(0, 0, 16'h0, 1, 16'h5555, "R5 load before reset");
    drive(0, 0, 16'h0, 1, 16'h0000, "R6 fault before reset");
    drive(1, 0, 16'h0, 0, 16'h0, "R7 R1 reset clears");
    drive(0, 1, INIT + 16'd1, 0, 16'h0, "R7 word=INIT probe");
    drive(0, 1, m_word, 0, 16'h0, "R7 next word probe");
    // R9: long run after reset
    for (int i = 0; i < 200; i++)
      drive(0, 1, 16'($urandom()), 0, 16'h0, "R9 R3 long run");
    drive(0, 0, 16'h0, 0, 16'h0, "R4 final hold");
    wait (q.size() == 0);
    @(posedge clk); #10;
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(20 * 20000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog all requirements actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule